// File: doc/BRIEF.md
# Four-Channel Prioritised Interrupt Vectoring Unit

This unit collects interrupt events from four counter/timer channels and presents them to a CPU as a single vectored, prioritised source. Each channel has its own enable. When an event reaches an enabled channel, the channel holds a pending request. The unit takes four consecutive places in an external daisy chain of interrupting devices. Within the unit, channel 0 outranks channel 1, which outranks channel 2, which outranks channel 3.

Software programs one base vector byte. When the CPU acknowledges, the unit drives a vector for the winning channel. The upper bits of that vector come from the base. The channel number is inserted in the bits above bit 0, and bit 0 is zero. The acknowledged channel stays in service until a return-from-interrupt strobe is seen while the channel owns the chain. While it is in service, it blocks its lower-priority neighbours and every device further down the chain. A higher-priority channel can still interrupt it, so service can nest.

Top module: `ctc_irq_chain`

## Requirements
- R1: After reset, `int_n` is 1, `vec_oe` is 0, no channel is pending or in service, and `ieo` follows `iei`.
- R2: A `ch_evt` pulse on a channel whose `ch_ie` bit is 1 makes that channel pending from the next cycle, and `int_n` goes low. A pulse on a channel whose enable bit is 0 has no effect, and `int_n` stays high.
- R3: Clearing a channel's `ch_ie` bit discards its pending request. Restoring the enable does not bring the request back.
- R4: When several channels are pending, the acknowledge selects the one with the lowest index.
- R5: Writing a byte with bit 0 equal to 0 loads the base vector. A write with bit 0 equal to 1 leaves the base unchanged. The vector driven on acknowledge is {base[7:3], channel[1:0], 1'b0}.
- R6: `ieo` is 0 while `iei` is 0, or while any channel is pending or in service. Otherwise `ieo` is 1.
- R7: While `iei` is 0, `int_n` is 1. An acknowledge in that state drives no vector (`vec_oe` is 0) and puts no channel in service.
- R8: An acknowledged channel leaves the pending state and enters service. While it is in service, requests from lower-priority channels are held off (`int_n` is 1), but a higher-priority pending channel still raises `int_n`.
- R9: A `reti` pulse while `iei` is 1 ends service of the highest-priority channel that is in service. A `reti` pulse while `iei` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_evt | input | 4 | One-cycle interrupt event per channel |
| ch_ie | input | 4 | Interrupt enable per channel |
| wr_en | input | 1 | Strobe that writes the base vector byte |
| wr_data | input | 8 | Written byte; bit 0 = 0 marks a vector word |
| iei | input | 1 | Daisy-chain enable from the higher-priority device |
| ieo | output | 1 | Daisy-chain enable to the lower-priority device |
| int_n | output | 1 | Active-low interrupt request to the CPU |
| inta | input | 1 | One-cycle interrupt acknowledge strobe |
| reti | input | 1 | One-cycle return-from-interrupt strobe |
| vec_oe | output | 1 | High while a vector is driven during acknowledge |
| vec_out | output | 8 | Interrupt vector of the winning channel |

## Verification
The hardest state to reach is nested service. It needs a low-priority channel in service, a still-lower channel pending behind it, and a higher-priority channel interrupting on top. It also needs return strobes that arrive while the chain input is held low. The bench builds this state step by step. It acknowledges channel 2, queues channel 3, raises channel 0 and serves it, drops `iei` around a return strobe, and then unwinds the rest. Separately, it sweeps every combination of enable mask and event pattern, each with its own base vector, and serves each pattern down to empty.

// File: rtl/ctc_irq_pkg.sv
// Package: shared sizes and vector formation for the interrupt vectoring unit.
// Assumes the channel count is a power of two, at most 4, so the channel
// field fits under the base bits of the vector byte.
package ctc_irq_pkg;
    localparam int unsigned NCH = 4;
    localparam int unsigned VW  = 8;
    localparam int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1;

    // Build the vector: base upper bits, channel number above bit 0, bit 0 clear.
    function automatic logic [VW-1:0] make_vec(input logic [VW-1:0] base,
                                               input logic [CW-1:0] chan);
        logic [VW-1:0] v;
        v = base;
        v[CW:1] = chan;
        v[0] = 1'b0;
        return v;
    endfunction
endpackage

// File: rtl/ctc_irq_vecreg.sv
// Module: holds the single programmed base vector.
// Assumes a write whose bit 0 is set belongs to another register and is ignored.
module ctc_irq_vecreg #(
    parameter int unsigned VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [VW-1:0] wr_data,
    output logic [VW-1:0] base_o
);
    logic [VW-1:0] base_q;

    // Capture the base vector on a write that is marked as a vector word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (wr_en && !wr_data[0])
            base_q <= wr_data;
    end

    assign base_o = base_q;

    // R5: base changes only through a vector-word write
    a_r5_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_data[0]) |=> $stable(base_q));
endmodule

// File: rtl/ctc_irq_slot.sv
// Module: one channel's place in the daisy chain.
// Keeps pending and in-service state and gates the chain enable.
// Assumes ack_i and reti_i are single-cycle strobes shared by all slots.
module ctc_irq_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic ie_i,
    input  logic ack_i,
    input  logic reti_i,
    input  logic chain_in,
    output logic chain_out,
    output logic irq_o
);
    logic pend_q, ins_q;
    logic take, done;

    // Request is visible only when everything above this slot lets it through.
    assign irq_o     = pend_q && chain_in;
    assign take      = ack_i && irq_o;
    assign done      = reti_i && ins_q && chain_in;
    assign chain_out = chain_in && !pend_q && !ins_q;

    // Pending: set by an enabled event, cleared by disable or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= ie_i && ((pend_q && !take) || evt_i);
    end

    // In service: set on acknowledge, cleared by a return seen while owning the chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ins_q <= 1'b0;
        else if (take)
            ins_q <= 1'b1;
        else if (done)
            ins_q <= 1'b0;
    end

    // R2: pending appears only after an enabled event
    a_r2_pend_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(evt_i && ie_i));
    // R3: a disabled channel holds no request in the next cycle
    a_r3_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_i && !evt_i |=> !pend_q);
    // R8: service starts only on an acknowledge
    a_r8_ins_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_q) |-> $past(ack_i && chain_in));
    // R9: service ends only on a return seen with the chain open
    a_r9_ins_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ins_q) |-> $past(reti_i && chain_in));
endmodule

// File: rtl/ctc_irq_chain.sv
// Module: top of the four-channel vectoring unit.
// Chains the slots in priority order, selects the winner, and forms the vector.
// Assumes the CPU holds inta for exactly one cycle per acknowledge.
module ctc_irq_chain
    import ctc_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NCH-1:0] ch_evt,
    input  logic [NCH-1:0] ch_ie,
    input  logic          wr_en,
    input  logic [VW-1:0] wr_data,
    input  logic          iei,
    output logic          ieo,
    output logic          int_n,
    input  logic          inta,
    input  logic          reti,
    output logic          vec_oe,
    output logic [VW-1:0] vec_out
);
    logic [NCH:0]   chain;
    logic [NCH-1:0] irq;
    logic [VW-1:0]  base;
    logic [CW-1:0]  win;

    assign chain[0] = iei;

    ctc_irq_vecreg #(.VW(VW)) vreg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .base_o(base)
    );

    // One slot per channel, index 0 nearest the chain input.
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        ctc_irq_slot slot_i (
            .clk(clk), .rst_n(rst_n), .evt_i(ch_evt[g]), .ie_i(ch_ie[g]),
            .ack_i(inta), .reti_i(reti), .chain_in(chain[g]),
            .chain_out(chain[g+1]), .irq_o(irq[g])
        );
    end

    // Encode the single requesting slot into a channel number.
    always_comb begin
        win = '0;
        for (int i = 0; i < NCH; i++)
            if (irq[i]) win = win | CW'(i);
    end

    assign ieo     = chain[NCH];
    assign int_n   = !(|irq);
    assign vec_oe  = inta && (|irq);
    assign vec_out = vec_oe ? make_vec(base, win) : '0;

    // R4: the chain lets at most one slot request at a time
    a_r4_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));
    // R7: nothing is driven while the chain input is closed
    a_r7_no_vec: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |-> !vec_oe && int_n);
    // R6: a request inside the unit closes the chain output
    a_r6_ieo_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> !ieo);
endmodule

// File: tb/ctc_irq_chain_tb_top.sv
`timescale 1ns/1ps
module ctc_irq_chain_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ch_evt = '0, ch_ie = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       iei = 1'b1, inta = 1'b0, reti = 1'b0;
    logic       ieo, int_n, vec_oe;
    logic [7:0] vec_out;
    int total = 0, bad = 0;
    logic [7:0] cur_base;

    always #10 clk = ~clk;

    ctc_irq_chain dut_i (
        .clk(clk), .rst_n(rst_n), .ch_evt(ch_evt), .ch_ie(ch_ie),
        .wr_en(wr_en), .wr_data(wr_data), .iei(iei), .ieo(ieo),
        .int_n(int_n), .inta(inta), .reti(reti), .vec_oe(vec_oe), .vec_out(vec_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0;
    endtask

    task automatic evt(input logic [3:0] p);
        ch_evt = p; cyc(); ch_evt = '0;
    endtask

    // Acknowledge and check the vector of channel w.
    task automatic ack(input string req, input int w);
        inta = 1'b1; #1;
        chk(req, {7'd0, vec_oe}, 8'd1);
        chk(req, vec_out, (cur_base & 8'hF8) | 8'(w << 1));
        cyc(); inta = 1'b0;
    endtask

    task automatic ret();
        reti = 1'b1; cyc(); reti = 1'b0;
    endtask

    initial begin
        #150000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(); cyc(); rst_n = 1'b1; cyc();
        // R1: reset state
        chk("R1 int_n", {7'd0, int_n}, 8'd1);
        chk("R1 vec_oe", {7'd0, vec_oe}, 8'd0);
        chk("R1 ieo", {7'd0, ieo}, 8'd1);
        iei = 1'b0; #1; chk("R1 ieo follows", {7'd0, ieo}, 8'd0); iei = 1'b1;
        cur_base = 8'h00;

        // Sweep of enable masks and event patterns (R2, R4, R5, R6, R8).
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 16; p++) begin
                logic [3:0] exp;
                cur_base = 8'((m * 16 + p) * 8);
                wr(cur_base);
                ch_ie = 4'(m);
                evt(4'(p));
                exp = 4'(m & p);
                chk("R2 int_n", {7'd0, int_n}, {7'd0, exp == 0});
                chk("R6 ieo", {7'd0, ieo}, {7'd0, exp == 0});
                while (exp != 0) begin
                    int w = 0;
                    for (int k = 3; k >= 0; k--) if (exp[k]) w = k;
                    ack("R4 R5 vector", w);
                    exp[w] = 1'b0;
                    // R8: in service blocks all lower channels
                    chk("R8 blocked", {7'd0, int_n}, 8'd1);
                    chk("R6 ieo in service", {7'd0, ieo}, 8'd0);
                    ret();
                    chk("R9 next", {7'd0, int_n}, {7'd0, exp == 0});
                end
                chk("R6 ieo idle", {7'd0, ieo}, 8'd1);
            end
        end

        // R5: a write with bit 0 set is ignored
        cur_base = 8'hA8; wr(cur_base);
        wr(8'h51);
        ch_ie = 4'hF; evt(4'b0010);
        ack("R5 ignored write", 1); ret();

        // R3: disabling drops a pending request
        evt(4'b0100);
        chk("R3 pending", {7'd0, int_n}, 8'd0);
        ch_ie = 4'b1011; cyc(); ch_ie = 4'hF; cyc();
        chk("R3 dropped", {7'd0, int_n}, 8'd1);
        chk("R3 ieo open", {7'd0, ieo}, 8'd1);

        // R7: closed chain input
        evt(4'b1000);
        iei = 1'b0; #1;
        chk("R7 int_n", {7'd0, int_n}, 8'd1);
        chk("R7 ieo", {7'd0, ieo}, 8'd0);
        inta = 1'b1; #1;
        chk("R7 no vec", {7'd0, vec_oe}, 8'd0);
        cyc(); inta = 1'b0; iei = 1'b1; #1;
        chk("R7 still pending", {7'd0, int_n}, 8'd0);
        ack("R7 later ack", 3); ret();

        // R8/R9: nested service
        evt(4'b0100); ack("R8 ch2", 2);
        evt(4'b1000);
        chk("R8 ch3 blocked", {7'd0, int_n}, 8'd1);
        evt(4'b0001);
        chk("R8 ch0 nests", {7'd0, int_n}, 8'd0);
        ack("R8 ch0 vec", 0);
        iei = 1'b0; ret(); iei = 1'b1; #1;
        chk("R9 reti ignored closed", {7'd0, int_n}, 8'd1);
        ret();   // ends ch0
        chk("R9 ch2 still serving", {7'd0, int_n}, 8'd1);
        ret();   // ends ch2
        chk("R9 ch3 released", {7'd0, int_n}, 8'd0);
        ack("R9 ch3 vec", 3); ret();
        chk("R6 all idle", {7'd0, ieo}, 8'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule